// File: doc/BRIEF.md
# Serial Flash Write-Protection Controller

This block is the write-guard logic for a 512 KB serial NOR flash. The command decoder gives it one-cycle strobes. It decides whether each status update, page program, sector erase, block erase or chip erase may go ahead, and answers with a one-cycle grant or reject. It holds three pieces of state:

- the arming latch, which must be set before any modification;
- a five-bit protection code, which selects a protected address window;
- two guard bits, which travel with the code.

The protection code selects one of several windows. The window sits at the top or the bottom of the array. It is sized either in 64 KB blocks (1/8, 1/4, 1/2 of the array) or in 4 KB sectors (4 KB to 32 KB). Some codes select nothing and some select the whole array.

The control is a four-state machine. It tracks two things: whether the device is awake or in deep power-down, and whether it is armed.

| State | Awake or asleep | Arming latch |
|---|---|---|
| `ST_LOCKED` | awake | clear |
| `ST_ARMED` | awake | set |
| `ST_DOZE_LOCKED` | asleep | clear |
| `ST_DOZE_ARMED` | asleep | set |

The transitions are:

- **arm:** `ST_LOCKED` to `ST_ARMED` on the arm strobe.
- **consume:** `ST_ARMED` to `ST_LOCKED` on disarm or any modify strobe, granted or not.
- **doze:** `ST_LOCKED` to `ST_DOZE_LOCKED`, and `ST_ARMED` to `ST_DOZE_ARMED`, on the sleep strobe.
- **wake:** each doze state returns to the awake state with the same latch value, on the wake strobe.

Power-up reset places the machine in `ST_LOCKED`.

Top module: `flash_protect_ctrl`

## Requirements
- R1: After reset `wr_latch`, `asleep`, `grant` and `reject` are 0, and `prot_code` and `guard_bits` hold their reset values (0 by default).
- R2: While awake, `cmd_arm` sets `wr_latch` on the following cycle.
- R3: While awake, `cmd_disarm`, `cmd_status_wr`, `cmd_program`, `cmd_sector_erase`, `cmd_block_erase` and `cmd_chip_erase` each clear `wr_latch`. This holds whether the request is granted or rejected.
- R4: A status write is granted only when the latch is set and `lock_pin_n` is 1. On a grant, `prot_code` takes `new_status[4:0]` and `guard_bits` takes `new_status[6:5]`. In every other case, while awake, the request is rejected and both fields keep their values.
- R5: With `prot_code[4]` = 0, the protected window is as follows:
  - `prot_code[2:0]` = 000 protects nothing;
  - `prot_code[2]` = 1 protects the whole array;
  - `prot_code[1:0]` = 01, 10 or 11 protects 64 KB, 128 KB or 256 KB;
  - the window sits at the top (ending at 7FFFFh) when `prot_code[3]` = 0, and at the bottom (starting at 0) when it is 1.
- R6: With `prot_code[4]` = 1, the window is sector-sized and placed by `prot_code[3]` as in R5:
  - `prot_code[2:0]` = 000 protects nothing;
  - 001, 010 or 011 protects 4 KB, 8 KB or 16 KB;
  - 100, 101 or 110 protects 32 KB;
  - 111 protects the whole array.
- R7: Each program or erase covers an aligned span: a page program covers 256 B, a sector erase 4 KB, and a block erase 64 KB, in each case the span that contains `tgt_addr`. The request is granted only when the latch is set and that span does not overlap the protected window. Otherwise it is rejected.
- R8: A chip erase is granted only when the latch is set and the code protects nothing. Otherwise it is rejected.
- R9: `cmd_sleep` puts an awake device to sleep (`asleep` = 1). While asleep, every strobe other than `cmd_wake` has no effect: there is no grant or reject, and the latch and status fields do not change.
- R10: `cmd_wake` returns a sleeping device to the awake state with its latch and status fields unchanged.
- R11: While awake, each modify strobe produces exactly one of `grant` or `reject`, as a single-cycle pulse on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| cmd_arm | input | 1 | Set the arming latch |
| cmd_disarm | input | 1 | Clear the arming latch |
| cmd_status_wr | input | 1 | Request to write protection code and guard bits |
| cmd_program | input | 1 | Page program request |
| cmd_sector_erase | input | 1 | 4 KB erase request |
| cmd_block_erase | input | 1 | 64 KB erase request |
| cmd_chip_erase | input | 1 | Whole-array erase request |
| cmd_sleep | input | 1 | Enter deep power-down |
| cmd_wake | input | 1 | Leave deep power-down |
| lock_pin_n | input | 1 | Hardware lock of the status fields, active low |
| new_status | input | 7 | Proposed {guard[1:0], code[4:0]} |
| tgt_addr | input | 19 | Byte address of the program or erase target |
| wr_latch | output | 1 | Arming latch |
| prot_code | output | 5 | Protection code |
| guard_bits | output | 2 | Guard bits |
| asleep | output | 1 | Deep power-down active |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |

## Verification
The bench walks all 32 protection codes and probes the first and last byte inside each window, plus the byte just outside it on either side. A decoder that swaps top and bottom, or sizes a window one step off, fails at those edges.

Directed cases cover four further corners:

- **Refused request still consumes the latch.** A design that keeps the latch set after a rejected request would grant a following request without a fresh arm.
- **Coarse span overlapping a small window.** A block erase whose 64 KB span touches a 4 KB top window must be refused. A design that checks only the target address would grant it.
- **Status write under the hardware lock.** A design that ignores `lock_pin_n` would change the code.
- **Strobes during sleep.** A design that does not filter them would grant requests or lose the latch while asleep.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    // Power and arming state of the guard
    typedef enum logic [1:0] {
        ST_LOCKED      = 2'd0,
        ST_ARMED       = 2'd1,
        ST_DOZE_LOCKED = 2'd2,
        ST_DOZE_ARMED  = 2'd3
    } guard_state_e;

    // Granularity of a modify target
    typedef enum logic [1:0] {
        SPAN_PAGE   = 2'd0,
        SPAN_SECTOR = 2'd1,
        SPAN_BLOCK  = 2'd2
    } span_kind_e;

endpackage

// File: rtl/fpc_region_decode.sv
module fpc_region_decode #(
    parameter int ADDR_W  = 19,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16
) (
    input  logic [4:0]        code,
    output logic              none,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam int                LG_W        = $clog2(ADDR_W + 1);
    localparam logic [ADDR_W:0]   ARRAY_BYTES = (ADDR_W + 1)'(1) << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP         = '1;

    logic            whole;
    logic [LG_W-1:0] lg;
    logic [ADDR_W:0] span;

    always_comb begin
        none  = 1'b0;
        whole = 1'b0;
        lg    = '0;
        if (code[2:0] == 3'b000) begin
            none = 1'b1;
        end else if (!code[4]) begin
            if (code[2]) whole = 1'b1;
            else         lg = LG_W'(BLK_LG - 1) + LG_W'(code[1:0]);
        end else if (code[2:0] == 3'b111) begin
            whole = 1'b1;
        end else if (code[2]) begin
            lg = LG_W'(SECT_LG + 3);
        end else begin
            lg = LG_W'(SECT_LG - 1) + LG_W'(code[1:0]);
        end

        span = (ADDR_W + 1)'(1) << lg;

        if (none || whole) begin
            lo = '0;
            hi = TOP;
        end else if (code[3]) begin
            lo = '0;
            hi = ADDR_W'(span - (ADDR_W + 1)'(1));
        end else begin
            lo = ADDR_W'(ARRAY_BYTES - span);
            hi = TOP;
        end
    end
endmodule

// File: rtl/fpc_target_span.sv
module fpc_target_span
    import fpc_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int PAGE_LG = 8,
    parameter int SECT_LG = 12,
    parameter int BLK_LG  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  span_kind_e        kind,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_LG) - 64'd1);
    localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'((64'd1 << SECT_LG) - 64'd1);
    localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'((64'd1 << BLK_LG) - 64'd1);

    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        unique case (kind)
            SPAN_PAGE:   low_mask = PAGE_MASK;
            SPAN_SECTOR: low_mask = SECT_MASK;
            default:     low_mask = BLK_MASK;
        endcase
        lo = addr & ~low_mask;
        hi = addr | low_mask;
    end
endmodule

// File: rtl/flash_protect_ctrl.sv
module flash_protect_ctrl
    import fpc_pkg::*;
#(
    parameter int         ADDR_W    = 19,
    parameter int         PAGE_LG   = 8,
    parameter int         SECT_LG   = 12,
    parameter int         BLK_LG    = 16,
    parameter logic [4:0] RST_CODE  = 5'd0,
    parameter logic [1:0] RST_GUARD = 2'd0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_arm,
    input  logic              cmd_disarm,
    input  logic              cmd_status_wr,
    input  logic              cmd_program,
    input  logic              cmd_sector_erase,
    input  logic              cmd_block_erase,
    input  logic              cmd_chip_erase,
    input  logic              cmd_sleep,
    input  logic              cmd_wake,
    input  logic              lock_pin_n,
    input  logic [6:0]        new_status,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic              wr_latch,
    output logic [4:0]        prot_code,
    output logic [1:0]        guard_bits,
    output logic              asleep,
    output logic              grant,
    output logic              reject
);
    guard_state_e      state_q, state_d;
    logic [4:0]        code_q;
    logic [1:0]        guard_q;
    logic              grant_q, reject_q;

    logic              p_none;
    logic [ADDR_W-1:0] p_lo, p_hi, t_lo, t_hi;
    span_kind_e        kind;
    logic              awake, armed, consumes, ranged, hit;

    // Protected window from the current code
    fpc_region_decode #(
        .ADDR_W(ADDR_W), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)
    ) u_region (
        .code(code_q), .none(p_none), .lo(p_lo), .hi(p_hi)
    );

    // Span touched by the request; its size follows the command
    always_comb begin
        if (cmd_sector_erase)     kind = SPAN_SECTOR;
        else if (cmd_block_erase) kind = SPAN_BLOCK;
        else                      kind = SPAN_PAGE;
    end

    fpc_target_span #(
        .ADDR_W(ADDR_W), .PAGE_LG(PAGE_LG), .SECT_LG(SECT_LG), .BLK_LG(BLK_LG)
    ) u_span (
        .addr(tgt_addr), .kind(kind), .lo(t_lo), .hi(t_hi)
    );

    assign awake    = (state_q == ST_LOCKED) || (state_q == ST_ARMED);
    assign armed    = (state_q == ST_ARMED);
    assign ranged   = cmd_program | cmd_sector_erase | cmd_block_erase;
    assign consumes = cmd_disarm | cmd_status_wr | ranged | cmd_chip_erase;
    assign hit      = !p_none && (t_lo <= p_hi) && (t_hi >= p_lo);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    // Transitions: arm, consume, doze, wake
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (cmd_arm)        state_d = ST_ARMED;
                else if (cmd_sleep) state_d = ST_DOZE_LOCKED;
            end
            ST_ARMED: begin
                if (consumes)       state_d = ST_LOCKED;
                else if (cmd_sleep) state_d = ST_DOZE_ARMED;
            end
            ST_DOZE_LOCKED: if (cmd_wake) state_d = ST_LOCKED;
            ST_DOZE_ARMED:  if (cmd_wake) state_d = ST_ARMED;
        endcase
    end

    // Outputs: verdict pulses and status fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
            code_q   <= RST_CODE;
            guard_q  <= RST_GUARD;
        end else begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
            if (awake) begin
                if (cmd_status_wr) begin
                    if (armed && lock_pin_n) begin
                        grant_q <= 1'b1;
                        code_q  <= new_status[4:0];
                        guard_q <= new_status[6:5];
                    end else begin
                        reject_q <= 1'b1;
                    end
                end else if (ranged) begin
                    if (armed && !hit) grant_q  <= 1'b1;
                    else               reject_q <= 1'b1;
                end else if (cmd_chip_erase) begin
                    if (armed && p_none) grant_q  <= 1'b1;
                    else                 reject_q <= 1'b1;
                end
            end
        end
    end

    assign wr_latch   = (state_q == ST_ARMED) || (state_q == ST_DOZE_ARMED);
    assign asleep     = !awake;
    assign prot_code  = code_q;
    assign guard_bits = guard_q;
    assign grant      = grant_q;
    assign reject     = reject_q;

    // R11
    grant_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_q && reject_q));

    // R9
    doze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake && !cmd_wake) |=> ($stable(code_q) && $stable(guard_q)
                                   && $stable(state_q) && !grant_q && !reject_q));

    // R4
    pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_pin_n |=> ($stable(code_q) && $stable(guard_q)));

    // R2
    arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKED && cmd_arm) |=> wr_latch);

    // R3
    consume_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && consumes) |=> !wr_latch);

    // R7
    grant_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_q |-> $past(state_q == ST_ARMED));

    // R5
    region_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !p_none |-> (p_lo <= p_hi));

endmodule

// File: tb/flash_protect_ctrl_test.sv
`timescale 1ns/1ps
module flash_protect_ctrl_test;

    localparam int OP_ARM = 0, OP_DISARM = 1, OP_STAT = 2, OP_PROG = 3,
                   OP_SECT = 4, OP_BLK = 5, OP_CHIP = 6, OP_SLEEP = 7, OP_WAKE = 8;
    localparam logic [18:0] TOP = 19'h7FFFF;

    // {none, lo, hi} per protection code, index = code
    localparam logic [38:0] REF [32] = '{
        {1'b1, 19'h00000, 19'h00000}, {1'b0, 19'h70000, 19'h7FFFF},
        {1'b0, 19'h60000, 19'h7FFFF}, {1'b0, 19'h40000, 19'h7FFFF},
        {1'b0, 19'h00000, 19'h7FFFF}, {1'b0, 19'h00000, 19'h7FFFF},
        {1'b0, 19'h00000, 19'h7FFFF}, {1'b0, 19'h00000, 19'h7FFFF},
        {1'b1, 19'h00000, 19'h00000}, {1'b0, 19'h00000, 19'h0FFFF},
        {1'b0, 19'h00000, 19'h1FFFF}, {1'b0, 19'h00000, 19'h3FFFF},
        {1'b0, 19'h00000, 19'h7FFFF}, {1'b0, 19'h00000, 19'h7FFFF},
        {1'b0, 19'h00000, 19'h7FFFF}, {1'b0, 19'h00000, 19'h7FFFF},
        {1'b1, 19'h00000, 19'h00000}, {1'b0, 19'h7F000, 19'h7FFFF},
        {1'b0, 19'h7E000, 19'h7FFFF}, {1'b0, 19'h7C000, 19'h7FFFF},
        {1'b0, 19'h78000, 19'h7FFFF}, {1'b0, 19'h78000, 19'h7FFFF},
        {1'b0, 19'h78000, 19'h7FFFF}, {1'b0, 19'h00000, 19'h7FFFF},
        {1'b1, 19'h00000, 19'h00000}, {1'b0, 19'h00000, 19'h00FFF},
        {1'b0, 19'h00000, 19'h01FFF}, {1'b0, 19'h00000, 19'h03FFF},
        {1'b0, 19'h00000, 19'h07FFF}, {1'b0, 19'h00000, 19'h07FFF},
        {1'b0, 19'h00000, 19'h07FFF}, {1'b0, 19'h00000, 19'h7FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  strobes = '0;
    logic        lock_pin_n = 1'b1;
    logic [6:0]  new_status = '0;
    logic [18:0] tgt_addr = '0;
    logic        wr_latch, asleep, grant, reject;
    logic [4:0]  prot_code;
    logic [1:0]  guard_bits;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flash_protect_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_arm(strobes[OP_ARM]), .cmd_disarm(strobes[OP_DISARM]),
        .cmd_status_wr(strobes[OP_STAT]), .cmd_program(strobes[OP_PROG]),
        .cmd_sector_erase(strobes[OP_SECT]), .cmd_block_erase(strobes[OP_BLK]),
        .cmd_chip_erase(strobes[OP_CHIP]), .cmd_sleep(strobes[OP_SLEEP]),
        .cmd_wake(strobes[OP_WAKE]), .lock_pin_n(lock_pin_n),
        .new_status(new_status), .tgt_addr(tgt_addr),
        .wr_latch(wr_latch), .prot_code(prot_code), .guard_bits(guard_bits),
        .asleep(asleep), .grant(grant), .reject(reject)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One-cycle strobe; returns at the negedge after the capturing posedge
    task automatic issue(input int op);
        @(negedge clk);
        strobes = 9'(1) << op;
        @(negedge clk);
        strobes = '0;
    endtask

    task automatic set_code(input logic [4:0] code);
        issue(OP_ARM);
        new_status = {2'b00, code};
        issue(OP_STAT);
        chk("R4", "code readback", 32'(prot_code), 32'(code));
    endtask

    task automatic probe(input string req, input int op,
                         input logic [18:0] addr, input logic exp);
        tgt_addr = addr;
        issue(OP_ARM);
        issue(op);
        chk(req, $sformatf("grant @%0h", addr), 32'(grant), 32'(exp));
        chk(req, $sformatf("reject @%0h", addr), 32'(reject), 32'(!exp));
        chk("R3", "latch after request", 32'(wr_latch), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "wr_latch", 32'(wr_latch), 0);
        chk("R1", "asleep", 32'(asleep), 0);
        chk("R1", "prot_code", 32'(prot_code), 0);
        chk("R1", "guard_bits", 32'(guard_bits), 0);
        chk("R1", "grant|reject", 32'(grant | reject), 0);

        // Table walk over all codes (R5, R6, R8)
        for (int c = 0; c < 32; c++) begin
            logic        none_e;
            logic [18:0] lo_e, hi_e;
            string       rq;
            {none_e, lo_e, hi_e} = REF[c];
            rq = (c < 16) ? "R5" : "R6";
            set_code(5'(c));
            if (none_e) begin
                probe(rq, OP_PROG, 19'h00000, 1'b1);
                probe(rq, OP_PROG, TOP, 1'b1);
            end else begin
                probe(rq, OP_PROG, lo_e, 1'b0);
                probe(rq, OP_PROG, hi_e, 1'b0);
                if (lo_e != 19'h0) probe(rq, OP_PROG, lo_e - 19'h1, 1'b1);
                if (hi_e != TOP)   probe(rq, OP_PROG, hi_e + 19'h1, 1'b1);
            end
            probe("R8", OP_CHIP, 19'h0, none_e);
        end

        // R4 status write with latch clear is refused
        set_code(5'd0);
        new_status = 7'h05;
        issue(OP_STAT);
        chk("R4", "reject without latch", 32'(reject), 1);
        chk("R4", "code kept", 32'(prot_code), 0);

        // R2 / R3 arm then disarm
        issue(OP_ARM);
        chk("R2", "latch set", 32'(wr_latch), 1);
        issue(OP_DISARM);
        chk("R3", "latch cleared by disarm", 32'(wr_latch), 0);

        // R4 lock pin blocks status write, R3 latch still consumed
        issue(OP_ARM);
        lock_pin_n = 1'b0;
        new_status = 7'h7F;
        issue(OP_STAT);
        chk("R4", "reject under lock", 32'(reject), 1);
        chk("R4", "code under lock", 32'(prot_code), 0);
        chk("R4", "guard under lock", 32'(guard_bits), 0);
        chk("R3", "latch after locked write", 32'(wr_latch), 0);
        lock_pin_n = 1'b1;

        // R4 guard bits field position
        issue(OP_ARM);
        new_status = 7'b1100000;
        issue(OP_STAT);
        chk("R4", "guard written", 32'(guard_bits), 3);
        chk("R4", "code with guard write", 32'(prot_code), 0);

        // R11 single-cycle verdict
        tgt_addr = 19'h0;
        issue(OP_ARM);
        issue(OP_PROG);
        chk("R11", "grant pulse", 32'(grant), 1);
        @(negedge clk);
        chk("R11", "grant drops", 32'(grant | reject), 0);

        // R7 program without latch refused
        issue(OP_PROG);
        chk("R7", "program without latch", 32'(reject), 1);

        // R7 sector and block spans
        set_code(5'b10001);
        probe("R7", OP_SECT, 19'h7EFFF, 1'b1);
        probe("R7", OP_SECT, 19'h7F000, 1'b0);
        probe("R7", OP_BLK, 19'h70000, 1'b0);
        probe("R7", OP_BLK, 19'h6FFFF, 1'b1);
        set_code(5'b00001);
        probe("R7", OP_BLK, 19'h6FFFF, 1'b1);
        probe("R7", OP_BLK, 19'h70000, 1'b0);
        probe("R7", OP_SECT, 19'h6F123, 1'b1);

        // R9 / R10 sleep keeps armed latch and filters commands
        issue(OP_ARM);
        issue(OP_SLEEP);
        chk("R9", "asleep", 32'(asleep), 1);
        chk("R9", "latch kept in sleep", 32'(wr_latch), 1);
        issue(OP_DISARM);
        chk("R9", "disarm ignored", 32'(wr_latch), 1);
        tgt_addr = 19'h0;
        issue(OP_PROG);
        chk("R9", "no verdict asleep", 32'(grant | reject), 0);
        new_status = 7'h1F;
        issue(OP_STAT);
        chk("R9", "status kept asleep", 32'(prot_code), 1);
        chk("R9", "no verdict on status", 32'(grant | reject), 0);
        issue(OP_WAKE);
        chk("R10", "awake", 32'(asleep), 0);
        chk("R10", "latch restored", 32'(wr_latch), 1);
        chk("R10", "code restored", 32'(prot_code), 1);
        issue(OP_PROG);
        chk("R10", "program after wake", 32'(grant), 1);

        // R9 / R10 sleep with latch clear, arm ignored
        issue(OP_SLEEP);
        issue(OP_ARM);
        chk("R9", "arm ignored asleep", 32'(wr_latch), 0);
        issue(OP_WAKE);
        chk("R10", "latch still clear", 32'(wr_latch), 0);
        chk("R10", "awake again", 32'(asleep), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule